// File: doc/BRIEF.md
# Regulator Output Supervisor and Startup Sequencer

This block is the digital supervisor of a single-phase step-down regulator. When the supply lockout signal says the supply is good, it first waits out a fixed window in which the analog side programs its over-current threshold. It then ramps a digital reference code linearly from zero to full scale, which stands for 0.8 V. While the reference ramps, it holds the low-side switch off until the high side has switched at least once. This keeps a pre-biased output from being pulled down through the low side.

The block watches five comparator flags taken from the sensed output voltage:

- above 1.0 V;
- below 0.6 V;
- above 0.89 V;
- below 0.71 V;
- above 0.4 V.

Each flag is synchronized and glitch-filtered before use. From the filtered flags the block drives a power-good output, a latched shut-off for undervoltage and over-current, and a latched overvoltage response. The overvoltage response keeps the high side off and forces the low side on whenever the output is above half the reference. An open sense input reads as overvoltage, so the overvoltage response needs nothing more than that flag. Every latch is cleared only by taking the supply lockout signal low. The reference DAC, the comparators and the error amplifier lie outside the block.

Top module: `vreg_supervisor`

## Requirements
- R1: While rst_n is low, ref_code is zero and ss_done, pgood, ls_mask, all_off and force_ls are all 0.
- R2: After uvlo_ok is first sampled high, ref_code stays zero and ss_done stays 0 for PROG_TICKS further clock edges (the programming window); the ramp starts on the edge that ends that window.
- R3: During the ramp, ref_code rises by exactly one every STEP_TICKS clock edges, from zero to all ones. ss_done rises on the same edge that ref_code reaches all ones, which is 1+PROG_TICKS+(2^REF_W-1)*STEP_TICKS edges after uvlo_ok is first sampled high. ss_done then stays high while no fault is latched.
- R4: ls_mask is 1 during the ramp until the first clock edge at which hs_switched is sampled high. If no such edge has occurred, ls_mask returns to 0 when the ramp ends.
- R5: pgood is 1 only while ss_done is 1, no fault is latched, and neither filtered window flag (cmp_win_hi, cmp_win_lo) is set. While pgood is low for a window excursion, ss_done stays 1 and all_off stays 0, so regulation continues.
- R6: Once ss_done is 1, a filtered cmp_uv latches all_off high, leaving force_ls at 0. Before ss_done, cmp_uv has no effect.
- R7: In any state except lockout, a filtered cmp_ov latches all_off high and ends the sequence. While that latch is held, force_ls equals the filtered cmp_half, repeatedly, and force_ls overrides all_off and ls_mask for the low side.
- R8: An oc_trip pulse during the ramp or after it latches all_off high. ref_code then returns to zero on the next edge, and ss_done does not rise.
- R9: The fault latches and the startup sequence are cleared only by uvlo_ok. One edge after uvlo_ok is sampled low, all_off, force_ls and ss_done are 0 and ref_code is zero; while uvlo_ok stays high, a latched all_off stays high.
- R10: A comparator flag changes inside the block only after the new level has held for three consecutive synchronized samples; a pulse lasting two clock cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Supply above lockout level, synchronous to clk; low acts as a power cycle |
| oc_trip | input | 1 | Over-current trip pulse from the current-sense logic, synchronous to clk |
| hs_switched | input | 1 | High side has switched in this cycle, synchronous to clk |
| cmp_ov | input | 1 | Sensed output above 1.0 V (also reads high when the sense input is open), asynchronous |
| cmp_uv | input | 1 | Sensed output below 0.6 V, asynchronous |
| cmp_win_hi | input | 1 | Sensed output above 0.89 V, asynchronous |
| cmp_win_lo | input | 1 | Sensed output below 0.71 V, asynchronous |
| cmp_half | input | 1 | Sensed output above 0.4 V, asynchronous |
| ref_code | output | REF_W | Soft-start reference code; all ones equals 0.8 V |
| ss_done | output | 1 | Soft start finished, regulating |
| pgood | output | 1 | Output within the power-good window |
| ls_mask | output | 1 | Hold the low-side switch off (pre-bias start) |
| all_off | output | 1 | Latched fault: high side off, low side off unless force_ls |
| force_ls | output | 1 | Drive the low-side switch on (overvoltage response) |

## Verification
If the sequencer state is wrong, the fault shows at the ports within one edge. A wrong window count moves the first ramp step, and the ss_done edge falls on a different cycle. A counter that skips or repeats a step breaks the one-code-per-step rise of ref_code at once. If a fault latch is lost or set by mistake, all_off shows it one edge after the filtered flag. force_ls fails to follow the half-reference flag within the filter delay of about six edges. If the low-side mask is held wrong, ls_mask stays high after an hs_switched edge or drops before one. The bench checks each of these at the exact edge the requirements predict.

// File: rtl/vsup_pkg.sv
package vsup_pkg;

  typedef enum logic [2:0] {
    ST_LOCKOUT,
    ST_PROG,
    ST_RAMP,
    ST_RUN,
    ST_HALT
  } seq_state_e;

  // Bit positions of the comparator flag vector
  localparam int FLG_OV     = 0;
  localparam int FLG_UV     = 1;
  localparam int FLG_WIN_HI = 2;
  localparam int FLG_WIN_LO = 3;
  localparam int FLG_HALF   = 4;
  localparam int NUM_FLG    = 5;

endpackage

// File: rtl/vsup_cmp_filter.sv
module vsup_cmp_filter #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] clean
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic       s1_q, s2_q;
    logic [2:0] hist_q;
    logic       out_q, out_nxt;

    // Output follows only after three equal synchronized samples (R10)
    always_comb begin
      out_nxt = out_q;
      if (hist_q == 3'b111)      out_nxt = 1'b1;
      else if (hist_q == 3'b000) out_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        hist_q <= 3'b000;
        out_q  <= 1'b0;
      end else begin
        s1_q   <= raw[g];
        s2_q   <= s1_q;
        hist_q <= {hist_q[1:0], s2_q};
        out_q  <= out_nxt;
      end
    end

    assign clean[g] = out_q;
  end

endmodule

// File: rtl/vsup_sequencer.sv
module vsup_sequencer
  import vsup_pkg::*;
#(
  parameter int PROG_TICKS = 500000,
  parameter int STEP_TICKS = 440,
  parameter int REF_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_ok,
  input  logic             halt_req,
  input  logic             hs_switched,
  output seq_state_e       state,
  output logic [REF_W-1:0] ref_code,
  output logic             ls_mask
);

  localparam int CNT_MAX = (PROG_TICKS > STEP_TICKS) ? PROG_TICKS : STEP_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_TICKS - 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_TICKS - 1);
  localparam logic [REF_W-1:0] REF_TOP   = '1;
  localparam logic [REF_W-1:0] REF_PRE   = REF_TOP - REF_W'(1);

  seq_state_e       st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [REF_W-1:0] ref_q, ref_nxt;
  logic             hs_seen_q, hs_seen_nxt;
  logic             cnt_en, ref_en;

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q;
    ref_nxt = ref_q;
    case (st_q)
      ST_LOCKOUT: begin
        cnt_nxt = '0;
        ref_nxt = '0;
        if (uvlo_ok) st_nxt = ST_PROG;
      end
      ST_PROG: begin
        if (cnt_q == PROG_LAST) begin
          cnt_nxt = '0;
          st_nxt  = ST_RAMP;
        end else begin
          cnt_nxt = cnt_q + CNT_W'(1);
        end
      end
      ST_RAMP: begin
        if (cnt_q == STEP_LAST) begin
          cnt_nxt = '0;
          ref_nxt = ref_q + REF_W'(1);
          if (ref_q == REF_PRE) st_nxt = ST_RUN;
        end else begin
          cnt_nxt = cnt_q + CNT_W'(1);
        end
      end
      ST_RUN:  ref_nxt = REF_TOP;
      ST_HALT: ref_nxt = '0;
      default: st_nxt = ST_LOCKOUT;
    endcase
    if (halt_req && (st_q != ST_LOCKOUT)) begin
      st_nxt  = ST_HALT;
      ref_nxt = '0;
    end
    if (!uvlo_ok) begin
      st_nxt  = ST_LOCKOUT;
      cnt_nxt = '0;
      ref_nxt = '0;
    end
  end

  // Low-side mask: armed in the ramp until the first high-side event (R4)
  always_comb begin
    hs_seen_nxt = 1'b0;
    if (st_q == ST_RAMP) hs_seen_nxt = hs_seen_q | hs_switched;
  end

  assign cnt_en = (st_q == ST_PROG) || (st_q == ST_RAMP) || (cnt_q != cnt_nxt);
  assign ref_en = (ref_q != ref_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_LOCKOUT;
      cnt_q     <= '0;
      ref_q     <= '0;
      hs_seen_q <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      hs_seen_q <= hs_seen_nxt;
      if (cnt_en) cnt_q <= cnt_nxt;
      if (ref_en) ref_q <= ref_nxt;
    end
  end

  assign state    = st_q;
  assign ref_code = ref_q;
  assign ls_mask  = (st_q == ST_RAMP) && !hs_seen_q;

endmodule

// File: rtl/vsup_fault_latch.sv
module vsup_fault_latch
  import vsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo_ok,
  input  seq_state_e state,
  input  logic       f_ov,
  input  logic       f_uv,
  input  logic       oc_trip,
  output logic       uv_lat,
  output logic       ov_lat,
  output logic       oc_lat
);

  logic uv_q, ov_q, oc_q;
  logic uv_nxt, ov_nxt, oc_nxt;
  logic uv_arm, ov_arm, oc_arm;

  assign ov_arm = (state != ST_LOCKOUT);
  assign uv_arm = (state == ST_RUN);
  assign oc_arm = (state == ST_RAMP) || (state == ST_RUN);

  always_comb begin
    if (!uvlo_ok) begin
      uv_nxt = 1'b0;
      ov_nxt = 1'b0;
      oc_nxt = 1'b0;
    end else begin
      uv_nxt = uv_q | (uv_arm & f_uv);
      ov_nxt = ov_q | (ov_arm & f_ov);
      oc_nxt = oc_q | (oc_arm & oc_trip);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_q <= 1'b0;
      ov_q <= 1'b0;
      oc_q <= 1'b0;
    end else begin
      uv_q <= uv_nxt;
      ov_q <= ov_nxt;
      oc_q <= oc_nxt;
    end
  end

  assign uv_lat = uv_q;
  assign ov_lat = ov_q;
  assign oc_lat = oc_q;

endmodule

// File: rtl/vreg_supervisor.sv
module vreg_supervisor
  import vsup_pkg::*;
#(
  parameter int PROG_TICKS = 500000,
  parameter int STEP_TICKS = 440,
  parameter int REF_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_ok,
  input  logic             oc_trip,
  input  logic             hs_switched,
  input  logic             cmp_ov,
  input  logic             cmp_uv,
  input  logic             cmp_win_hi,
  input  logic             cmp_win_lo,
  input  logic             cmp_half,
  output logic [REF_W-1:0] ref_code,
  output logic             ss_done,
  output logic             pgood,
  output logic             ls_mask,
  output logic             all_off,
  output logic             force_ls
);

  logic [NUM_FLG-1:0] raw_flg, flg;
  seq_state_e         state;
  logic               uv_lat, ov_lat, oc_lat;

  always_comb begin
    raw_flg             = '0;
    raw_flg[FLG_OV]     = cmp_ov;
    raw_flg[FLG_UV]     = cmp_uv;
    raw_flg[FLG_WIN_HI] = cmp_win_hi;
    raw_flg[FLG_WIN_LO] = cmp_win_lo;
    raw_flg[FLG_HALF]   = cmp_half;
  end

  vsup_cmp_filter #(.N(NUM_FLG)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_flg),
    .clean (flg)
  );

  vsup_sequencer #(
    .PROG_TICKS (PROG_TICKS),
    .STEP_TICKS (STEP_TICKS),
    .REF_W      (REF_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .uvlo_ok     (uvlo_ok),
    .halt_req    (all_off),
    .hs_switched (hs_switched),
    .state       (state),
    .ref_code    (ref_code),
    .ls_mask     (ls_mask)
  );

  vsup_fault_latch u_flt (
    .clk     (clk),
    .rst_n   (rst_n),
    .uvlo_ok (uvlo_ok),
    .state   (state),
    .f_ov    (flg[FLG_OV]),
    .f_uv    (flg[FLG_UV]),
    .oc_trip (oc_trip),
    .uv_lat  (uv_lat),
    .ov_lat  (ov_lat),
    .oc_lat  (oc_lat)
  );

  assign all_off  = uv_lat | ov_lat | oc_lat;
  assign force_ls = ov_lat & flg[FLG_HALF];
  assign ss_done  = (state == ST_RUN);
  assign pgood    = ss_done & ~all_off & ~flg[FLG_WIN_HI] & ~flg[FLG_WIN_LO];

endmodule

// File: rtl/vsup_checker.sv
module vsup_checker #(
  parameter int REF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uvlo_ok,
  input logic [REF_W-1:0] ref_code,
  input logic             ss_done,
  input logic             pgood,
  input logic             ls_mask,
  input logic             all_off,
  input logic             force_ls
);

  // R3: the reference moves up by at most one code and never falls without a cause
  a_r3_ref_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uvlo_ok) && !$past(all_off)) |->
      ((ref_code == $past(ref_code)) || (ref_code == $past(ref_code) + REF_W'(1))));

  // R3: soft start ends only at full scale
  a_r3_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (ref_code == {REF_W{1'b1}}));

  // R4: the low-side mask exists only before soft start ends
  a_r4_mask_in_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    ls_mask |-> !ss_done);

  // R5: power good needs a finished soft start and no fault
  a_r5_pgood_after_ss: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (ss_done && !all_off));

  // R7: forced low side only under a latched fault
  a_r7_force_latched: assert property (@(posedge clk) disable iff (!rst_n)
    force_ls |-> all_off);

  // R9: a latched fault survives while the supply stays up
  a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (all_off && uvlo_ok) |=> all_off);

  // R9: lockout clears everything on the next edge
  a_r9_lockout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!all_off && !force_ls && !ss_done && (ref_code == '0)));

endmodule

bind vreg_supervisor vsup_checker #(.REF_W(REF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .uvlo_ok  (uvlo_ok),
  .ref_code (ref_code),
  .ss_done  (ss_done),
  .pgood    (pgood),
  .ls_mask  (ls_mask),
  .all_off  (all_off),
  .force_ls (force_ls)
);

// File: tb/vreg_supervisor_bench.sv
`timescale 1ns/1ps
module vreg_supervisor_bench;

  localparam int PROG  = 8;
  localparam int STEP  = 2;
  localparam int RW    = 4;
  localparam int FULL  = (1 << RW) - 1;
  localparam int T_END = 1 + PROG + FULL * STEP;

  // Window vectors: {cmp_win_hi, cmp_win_lo, expected pgood}
  localparam logic [2:0] WIN_VEC [0:4] = '{3'b001, 3'b100, 3'b001, 3'b010, 3'b001};

  logic clk = 1'b0;
  logic rst_n;
  logic uvlo_ok, oc_trip, hs_switched;
  logic cmp_ov, cmp_uv, cmp_win_hi, cmp_win_lo, cmp_half;
  logic [RW-1:0] ref_code;
  logic ss_done, pgood, ls_mask, all_off, force_ls;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vreg_supervisor #(.PROG_TICKS(PROG), .STEP_TICKS(STEP), .REF_W(RW)) u_vreg_supervisor (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .oc_trip(oc_trip),
    .hs_switched(hs_switched), .cmp_ov(cmp_ov), .cmp_uv(cmp_uv),
    .cmp_win_hi(cmp_win_hi), .cmp_win_lo(cmp_win_lo), .cmp_half(cmp_half),
    .ref_code(ref_code), .ss_done(ss_done), .pgood(pgood), .ls_mask(ls_mask),
    .all_off(all_off), .force_ls(force_ls)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic power_cycle();
    uvlo_ok = 1'b0; cmp_ov = 1'b0; cmp_uv = 1'b0;
    cmp_win_hi = 1'b0; cmp_win_lo = 1'b0; cmp_half = 1'b0;
    edges(10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uvlo_ok = 1'b0; oc_trip = 1'b0; hs_switched = 1'b0;
    cmp_ov = 1'b0; cmp_uv = 1'b0; cmp_win_hi = 1'b0; cmp_win_lo = 1'b0; cmp_half = 1'b0;
    edges(3);
    // R1 reset state
    chk("R1 ref_code", ref_code, 0);
    chk("R1 outputs", {ss_done, pgood, ls_mask, all_off, force_ls}, 0);
    #1 rst_n = 1'b1;
    edges(2);

    // R2 / R3 startup timing
    uvlo_ok = 1'b1;
    edges(PROG);
    chk("R2 ref zero in window", ref_code, 0);
    chk("R2 no mask in window", ls_mask, 0);
    edges(1);
    chk("R2 ramp begins, mask set (R4)", ls_mask, 1);
    edges(STEP * 5);
    chk("R3 ramp step 5", ref_code, 5);
    edges(T_END - 1 - (PROG + 1 + STEP * 5));
    chk("R3 ss_done before end", ss_done, 0);
    edges(1);
    chk("R3 ss_done at end", ss_done, 1);
    chk("R3 ref full", ref_code, FULL);
    chk("R4 mask released without hs event", ls_mask, 0);
    chk("R5 pgood after ss", pgood, 1);

    // R5 window vectors
    foreach (WIN_VEC[i]) begin
      cmp_win_hi = WIN_VEC[i][2];
      cmp_win_lo = WIN_VEC[i][1];
      edges(8);
      chk("R5 pgood window", pgood, int'(WIN_VEC[i][0]));
      chk("R5 regulation continues", {ss_done, all_off}, 2);
    end

    // R10 two-cycle glitch on overvoltage flag
    cmp_ov = 1'b1; cmp_half = 1'b1;
    edges(2);
    cmp_ov = 1'b0;
    edges(10);
    chk("R10 glitch ignored all_off", all_off, 0);
    chk("R10 glitch ignored force_ls", force_ls, 0);

    // R7 overvoltage latch and low-side toggling
    cmp_ov = 1'b1; cmp_win_hi = 1'b1;
    edges(10);
    chk("R7 ov all_off", all_off, 1);
    chk("R7 ov force_ls", force_ls, 1);
    chk("R7 ov ends sequence", {ss_done, pgood}, 0);
    cmp_ov = 1'b0; cmp_win_hi = 1'b0; cmp_half = 1'b0;
    edges(10);
    chk("R7 ls released below half", force_ls, 0);
    chk("R9 ov latch held", all_off, 1);
    cmp_half = 1'b1;
    edges(10);
    chk("R7 ls forced again", force_ls, 1);

    // R9 lockout clears
    uvlo_ok = 1'b0;
    edges(1);
    chk("R9 lockout clears", {all_off, force_ls, ss_done}, 0);
    power_cycle();

    // R4 hs event releases mask, R8 over-current during ramp
    uvlo_ok = 1'b1;
    edges(PROG + 4);
    chk("R4 mask in ramp", ls_mask, 1);
    hs_switched = 1'b1;
    edges(1);
    hs_switched = 1'b0;
    chk("R4 mask off after hs event", ls_mask, 0);
    chk("R4 still ramping", ss_done, 0);
    oc_trip = 1'b1;
    edges(1);
    oc_trip = 1'b0;
    chk("R8 oc latches", all_off, 1);
    edges(1);
    chk("R8 ref back to zero", ref_code, 0);
    edges(T_END + 5);
    chk("R8 ss_done never rises", ss_done, 0);
    chk("R8 latch held", all_off, 1);
    power_cycle();
    chk("R9 cleared after cycle", all_off, 0);

    // R6 undervoltage ignored in ramp, latched after
    cmp_uv = 1'b1; cmp_win_lo = 1'b1; uvlo_ok = 1'b1;
    edges(25);
    chk("R6 uv ignored before ss_done", all_off, 0);
    cmp_uv = 1'b0; cmp_win_lo = 1'b0;
    edges(T_END - 25);
    chk("R6 ss_done reached", ss_done, 1);
    chk("R6 pgood", pgood, 1);
    cmp_uv = 1'b1; cmp_win_lo = 1'b1;
    edges(10);
    chk("R6 uv latches", all_off, 1);
    chk("R6 no forced ls", force_ls, 0);
    chk("R6 pgood low", pgood, 0);
    power_cycle();

    // R7 open sense before soft start
    cmp_ov = 1'b1; cmp_half = 1'b1; uvlo_ok = 1'b1;
    edges(PROG);
    chk("R7 ov in window latches", all_off, 1);
    chk("R7 ov in window forces ls", force_ls, 1);
    edges(T_END);
    chk("R7 no soft start", {ss_done, ref_code}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule